// File: doc/BRIEF.md
# ACPI Fixed-Feature PM1 Register Block

This block holds the fixed-feature power-management registers that an operating system uses to field power events and to request sleep states. Software reaches it over a narrow I/O bus with byte offsets. The block holds three 16-bit registers: event status, event enable and power control. It also holds a free-running power-management timer. The timer advances on an external strobe that runs at the standard 3.579545 MHz rate. The status register is cleared by writing ones. Hardware sets its bits on timer overflow, on a power-button press, and on resume from a suspend-to-RAM request.

The block drives a level-sensitive system control interrupt (SCI). This line is high while any enabled event is pending. An externally held hotplug event with its own enable also holds the line high. A write to the control register with the sleep-enable bit set acts on the sleep type carried in the same write: one code asks for power-off, and another asks for a suspend-and-reset sequence. The sleep-enable bit itself is never stored. A legacy power-management command byte can switch SCI delivery on or off. An enable input gates the whole register window, so the block sees no access while it is unmapped.

Top module: `pm1_regfile`

## Requirements
- R1: After reset, status, enable, control and timer all read zero, SCI is low and the three request outputs are low.
- R2: With `io_en` and `rd_en` high, offset 0x0 reads status, 0x2 reads enable, 0x4 reads control and 0x8 reads the timer zero-extended to 32 bits. Every other offset, and any read with `io_en` or `rd_en` low, returns zero. Writes made while `io_en` is low change no register.
- R3: The timer increments by exactly one on each clock edge where `tick` is high, holds otherwise, and wraps modulo 2^TMR_W (TMR_W = 24 by default).
- R4: Status bit 0 (timer overflow) sets on the tick where the timer passes a multiple of 2^(TMR_W-1), including the wrap to zero. Once cleared, it stays clear until the next such multiple.
- R5: A write to status clears each bit written as one and leaves the bits written as zero unchanged. A hardware set in the same cycle wins over the clear.
- R6: The enable register stores all 16 written bits and reads them back unchanged.
- R7: SCI is high while (status AND enable) is non-zero in any of bits 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC). SCI is also high while both `gpe_hp_sts` and `gpe_hp_en` are high. SCI is low otherwise.
- R8: A control write stores the written value with bit 13 (sleep enable) forced to zero. Bits 12:10 hold the sleep type and bit 0 is SCI enable.
- R9: A control write with bit 13 set and sleep type 0 raises `shutdown_req` for exactly one cycle, in the cycle after the write edge.
- R10: A control write with bit 13 set and sleep type 1 sets status bits 15 (wake) and 8 (power button), and raises `reset_req` and `s3_pulse` together for one cycle. Sleep types 2 to 7 raise no request.
- R11: An accepted command byte 0xF1 on `apm_cmd` sets control bit 0, and 0xF0 clears it. Any other byte leaves control unchanged.
- R12: A `pwrbtn_evt` pulse sets status bit 8 only while enable bit 8 is set. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | Register window decoded and enabled |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; rdata is valid while it is high |
| addr | input | ADDR_W (4) | Byte offset within the window |
| wdata | input | 16 | Write data |
| rdata | output | DATA_W (32) | Read data, combinational from addr |
| tick | input | 1 | Timer strobe at the PM timer rate |
| pwrbtn_evt | input | 1 | Power-button press, one cycle |
| apm_valid | input | 1 | Command byte on apm_cmd is valid |
| apm_cmd | input | 8 | Legacy power-management command byte |
| gpe_hp_sts | input | 1 | Hotplug general-purpose event pending |
| gpe_hp_en | input | 1 | Hotplug general-purpose event enabled |
| sci | output | 1 | Level-sensitive system control interrupt |
| shutdown_req | output | 1 | Power-off request pulse |
| reset_req | output | 1 | System reset request pulse |
| s3_pulse | output | 1 | Suspend-to-RAM indication pulse |

## Verification
The timer runs through runs of ticks that stop just short of the overflow point, land exactly on it, and run through the wrap to zero. These runs separate a crossing detector from a fixed compare. They also show that clearing the status bit moves the next overflow forward rather than setting it again at once. Status writes use an all-zero pattern and a single one. These two patterns separate write-one-to-clear from a plain store. SCI is driven by one event source at a time, both with its enable set and with a different enable bit set, so that a wrong bit position shows up as a level error. Sleep writes cover type 0, type 1 and type 7, and each is checked in the request cycle and the cycle after, to catch stuck or missing pulses. The command-byte path is tried with both valid codes and one unrelated byte.

// File: rtl/pm1_pkg.sv
package pm1_pkg;
  localparam int REG_W = 16;

  // status / enable bit positions (shared by the two registers)
  localparam int EVB_TMR    = 0;
  localparam int EVB_GLOCK  = 5;
  localparam int EVB_PWRBTN = 8;
  localparam int EVB_RTC    = 10;
  localparam int EVB_WAKE   = 15;

  // control bit positions
  localparam int CTB_SCIEN  = 0;
  localparam int CTB_TYP_LO = 10;
  localparam int CTB_SLPEN  = 13;

  localparam logic [REG_W-1:0] SCI_SRC_MASK =
    REG_W'((1 << EVB_TMR) | (1 << EVB_GLOCK) | (1 << EVB_PWRBTN) | (1 << EVB_RTC));

  localparam logic [2:0] SLP_POWEROFF = 3'd0;
  localparam logic [2:0] SLP_SUSPEND  = 3'd1;

  localparam logic [7:0] CMD_SCI_ON  = 8'hF1;
  localparam logic [7:0] CMD_SCI_OFF = 8'hF0;

  localparam logic [7:0] OFS_STATUS = 8'h00;
  localparam logic [7:0] OFS_ENABLE = 8'h02;
  localparam logic [7:0] OFS_CTRL   = 8'h04;
  localparam logic [7:0] OFS_TIMER  = 8'h08;
endpackage

// File: rtl/pm1_timer.sv
module pm1_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [TMR_W-1:0] count,
  output logic             crossed
);
  localparam int MSB = TMR_W - 1;

  logic [TMR_W-1:0] count_inc;
  logic [TMR_W-1:0] count_d;

  always_comb begin
    count_inc = count + 1'b1;
    count_d   = tick ? count_inc : count;
    // top bit flips exactly when a multiple of 2^(TMR_W-1) is passed
    crossed   = tick & (count[MSB] ^ count_inc[MSB]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (tick) begin
      count <= count_d;
    end
  end
endmodule

// File: rtl/pm1_status.sv
module pm1_status #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] sts
);
  logic [W-1:0] sts_d;
  logic         upd;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // hardware set wins over a software clear in the same cycle
    assign sts_d[i] = set_vec[i] | (sts[i] & ~(clr_en & clr_mask[i]));
  end

  assign upd = clr_en | (|set_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
    end else if (upd) begin
      sts <= sts_d;
    end
  end
endmodule

// File: rtl/pm1_ctrl.sv
module pm1_ctrl
  import pm1_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             apm_valid,
  input  logic [7:0]       apm_cmd,
  output logic [REG_W-1:0] ctrl,
  output logic             wake_set,
  output logic             shutdown_req,
  output logic             reset_req,
  output logic             s3_pulse
);
  logic [REG_W-1:0] ctrl_d;
  logic             ctrl_upd;
  logic             sleep_go;
  logic [2:0]       sleep_typ;
  logic             off_d;
  logic             susp_d;
  logic             cmd_on;
  logic             cmd_off;

  always_comb begin
    sleep_typ = wdata[CTB_TYP_LO +: 3];
    sleep_go  = wr_en & wdata[CTB_SLPEN];
    off_d     = sleep_go & (sleep_typ == SLP_POWEROFF);
    susp_d    = sleep_go & (sleep_typ == SLP_SUSPEND);
    wake_set  = susp_d;
    cmd_on    = apm_valid & (apm_cmd == CMD_SCI_ON);
    cmd_off   = apm_valid & (apm_cmd == CMD_SCI_OFF);

    ctrl_d = ctrl;
    if (wr_en) begin
      ctrl_d = wdata;
      ctrl_d[CTB_SLPEN] = 1'b0;
    end
    if (cmd_on) begin
      ctrl_d[CTB_SCIEN] = 1'b1;
    end else if (cmd_off) begin
      ctrl_d[CTB_SCIEN] = 1'b0;
    end
    ctrl_upd = wr_en | cmd_on | cmd_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (ctrl_upd) begin
      ctrl <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
      s3_pulse     <= 1'b0;
    end else begin
      shutdown_req <= off_d;
      reset_req    <= susp_d;
      s3_pulse     <= susp_d;
    end
  end
endmodule

// File: rtl/pm1_regfile.sv
module pm1_regfile
  import pm1_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tick,
  input  logic              pwrbtn_evt,
  input  logic              apm_valid,
  input  logic [7:0]        apm_cmd,
  input  logic              gpe_hp_sts,
  input  logic              gpe_hp_en,
  output logic              sci,
  output logic              shutdown_req,
  output logic              reset_req,
  output logic              s3_pulse
);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(OFS_TIMER);

  logic             wr_sts, wr_en_reg, wr_ctl;
  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_cross;
  logic [REG_W-1:0] sts_q;
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] en_d;
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] set_vec;
  logic             wake_set;

  always_comb begin
    wr_sts    = io_en & wr_en & (addr == A_STS);
    wr_en_reg = io_en & wr_en & (addr == A_EN);
    wr_ctl    = io_en & wr_en & (addr == A_CTL);
  end

  pm1_timer #(.TMR_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .count   (tmr_cnt),
    .crossed (tmr_cross)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[EVB_TMR]    = tmr_cross;
    set_vec[EVB_PWRBTN] = (pwrbtn_evt & en_q[EVB_PWRBTN]) | wake_set;
    set_vec[EVB_WAKE]   = wake_set;
  end

  pm1_status #(.W(REG_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (wr_sts),
    .clr_mask (wdata),
    .set_vec  (set_vec),
    .sts      (sts_q)
  );

  pm1_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_ctl),
    .wdata        (wdata),
    .apm_valid    (apm_valid),
    .apm_cmd      (apm_cmd),
    .ctrl         (ctrl_q),
    .wake_set     (wake_set),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req),
    .s3_pulse     (s3_pulse)
  );

  // enable register
  assign en_d = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en_reg) begin
      en_q <= en_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (io_en && rd_en) begin
      case (addr)
        A_STS:   rdata = DATA_W'(sts_q);
        A_EN:    rdata = DATA_W'(en_q);
        A_CTL:   rdata = DATA_W'(ctrl_q);
        A_TMR:   rdata = DATA_W'(tmr_cnt);
        default: rdata = '0;
      endcase
    end
  end

  // interrupt level
  assign sci = (|(sts_q & en_q & SCI_SRC_MASK)) | (gpe_hp_sts & gpe_hp_en);
endmodule

// File: rtl/pm1_regfile_chk.sv
module pm1_regfile_chk #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_en,
  input logic             wr_en,
  input logic             tick,
  input logic             pwrbtn_evt,
  input logic             gpe_hp_sts,
  input logic             gpe_hp_en,
  input logic [TMR_W-1:0] tmr_cnt,
  input logic [15:0]      sts_q,
  input logic [15:0]      ctrl_q,
  input logic             sci,
  input logic             shutdown_req,
  input logic             reset_req,
  input logic             s3_pulse
);
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tmr_cnt)); // R3

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> tmr_cnt == TMR_W'($past(tmr_cnt) + 1'b1)); // R3

  AST_STS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!(io_en && wr_en) && !tick && !pwrbtn_evt) |=> $stable(sts_q)); // R5

  AST_GPE_RAISES_SCI: assert property (@(posedge clk) disable iff (!rst_n)
    (gpe_hp_sts && gpe_hp_en) |-> sci); // R7

  AST_SLPEN_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[13]); // R8

  AST_OFF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req); // R9

  AST_S3_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    s3_pulse |-> reset_req); // R10

  AST_SLEEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reset_req)); // R10
endmodule

bind pm1_regfile pm1_regfile_chk #(.TMR_W(TMR_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_en        (io_en),
  .wr_en        (wr_en),
  .tick         (tick),
  .pwrbtn_evt   (pwrbtn_evt),
  .gpe_hp_sts   (gpe_hp_sts),
  .gpe_hp_en    (gpe_hp_en),
  .tmr_cnt      (tmr_cnt),
  .sts_q        (sts_q),
  .ctrl_q       (ctrl_q),
  .sci          (sci),
  .shutdown_req (shutdown_req),
  .reset_req    (reset_req),
  .s3_pulse     (s3_pulse)
);

// File: tb/test_pm1_regfile.sv
module test_pm1_regfile;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int TW = 12;   // short timer keeps overflow runs within budget
  localparam int HALF = 1 << (TW - 1);

  localparam int K_RD    = 0;
  localparam int K_SCI   = 1;
  localparam int K_PULSE = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          io_en, wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [15:0]   wdata;
  logic [DW-1:0] rdata;
  logic          tick, pwrbtn_evt, apm_valid;
  logic [7:0]    apm_cmd;
  logic          gpe_hp_sts, gpe_hp_en;
  logic          sci, shutdown_req, reset_req, s3_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int          q_kind[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  pm1_regfile #(.ADDR_W(AW), .DATA_W(DW), .TMR_W(TW)) i_pm1_regfile (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tick(tick),
    .pwrbtn_evt(pwrbtn_evt), .apm_valid(apm_valid), .apm_cmd(apm_cmd),
    .gpe_hp_sts(gpe_hp_sts), .gpe_hp_en(gpe_hp_en), .sci(sci),
    .shutdown_req(shutdown_req), .reset_req(reset_req), .s3_pulse(s3_pulse)
  );

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    while (q_kind.size() > 0) begin
      int          k;
      logic [31:0] e;
      logic [31:0] a;
      string       t;
      k = q_kind.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      case (k)
        K_RD:    a = rdata;
        K_SCI:   a = {31'd0, sci};
        default: a = {29'd0, shutdown_req, reset_req, s3_pulse};
      endcase
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
      end
    end
  end

  task automatic expect_item(input int k, input logic [31:0] e, input string t);
    q_kind.push_back(k);
    q_exp.push_back(e);
    q_tag.push_back(t);
    @(negedge clk);
    #1;
  endtask

  task automatic chk_rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    addr  = a;
    rd_en = 1'b1;
    expect_item(K_RD, e, t);
    rd_en = 1'b0;
  endtask

  task automatic chk_sci(input logic e, input string t);
    expect_item(K_SCI, {31'd0, e}, t);
  endtask

  // order {shutdown_req, reset_req, s3_pulse}
  task automatic chk_pulse(input logic [2:0] e, input string t);
    expect_item(K_PULSE, {29'd0, e}, t);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    tick = 1'b0;
  endtask

  task automatic press_button();
    @(posedge clk); #1;
    pwrbtn_evt = 1'b1;
    @(posedge clk); #1;
    pwrbtn_evt = 1'b0;
  endtask

  task automatic apm(input logic [7:0] c);
    @(posedge clk); #1;
    apm_cmd = c; apm_valid = 1'b1;
    @(posedge clk); #1;
    apm_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_en = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0;
    wdata = '0; tick = 1'b0; pwrbtn_evt = 1'b0; apm_valid = 1'b0;
    apm_cmd = '0; gpe_hp_sts = 1'b0; gpe_hp_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_rd(4'h0, 32'h0, "R1 status after reset");
    chk_rd(4'h2, 32'h0, "R1 enable after reset");
    chk_rd(4'h4, 32'h0, "R1 control after reset");
    chk_rd(4'h8, 32'h0, "R1 timer after reset");
    chk_sci(1'b0, "R1 sci after reset");
    chk_pulse(3'b000, "R1 requests after reset");

    // R6 enable store
    wr(4'h2, 16'hFFFF);
    chk_rd(4'h2, 32'hFFFF, "R6 enable all ones");
    wr(4'h2, 16'h5A3C);
    chk_rd(4'h2, 32'h5A3C, "R6 enable pattern");
    wr(4'h2, 16'h0000);

    // R2 unmapped offsets and read strobe
    chk_rd(4'h6, 32'h0, "R2 offset 0x6 reads zero");
    chk_rd(4'hC, 32'h0, "R2 offset 0xC reads zero");

    // R3 / R4 timer and overflow
    ticks(5);
    chk_rd(4'h8, 32'd5, "R3 timer after 5 ticks");
    ticks(HALF - 6);
    chk_rd(4'h8, HALF - 1, "R3 timer just below overflow");
    chk_rd(4'h0, 32'h0, "R4 no overflow before crossing");
    ticks(1);
    chk_rd(4'h8, HALF, "R3 timer at crossing");
    chk_rd(4'h0, 32'h1, "R4 overflow set at crossing");

    // R5 write-one-to-clear
    wr(4'h0, 16'h0000);
    chk_rd(4'h0, 32'h1, "R5 zero write keeps bit");
    wr(4'h0, 16'h0001);
    chk_rd(4'h0, 32'h0, "R5 one write clears bit");
    ticks(3);
    chk_rd(4'h0, 32'h0, "R4 stays clear until next multiple");
    ticks(HALF - 3);
    chk_rd(4'h8, 32'h0, "R3 timer wraps to zero");
    chk_rd(4'h0, 32'h1, "R4 overflow set on wrap");

    // R7 SCI sources
    chk_sci(1'b0, "R7 sci low with enable clear");
    wr(4'h2, 16'h0001);
    chk_sci(1'b1, "R7 sci from timer bit 0");
    wr(4'h2, 16'h0100);
    chk_sci(1'b0, "R7 sci low with other enable");
    wr(4'h0, 16'h0001);
    chk_rd(4'h0, 32'h0, "R5 timer status cleared");

    // R12 power button
    wr(4'h2, 16'h0000);
    press_button();
    chk_rd(4'h0, 32'h0, "R12 press ignored when disabled");
    wr(4'h2, 16'h0100);
    press_button();
    chk_rd(4'h0, 32'h0100, "R12 press sets bit 8");
    chk_sci(1'b1, "R7 sci from power button");
    wr(4'h0, 16'h0100);
    chk_sci(1'b0, "R7 sci drops after clear");

    // R7 hotplug path
    gpe_hp_sts = 1'b1;
    chk_sci(1'b0, "R7 hotplug pending but disabled");
    gpe_hp_en = 1'b1;
    chk_sci(1'b1, "R7 hotplug pending and enabled");
    gpe_hp_sts = 1'b0; gpe_hp_en = 1'b0;
    chk_sci(1'b0, "R7 hotplug removed");

    // R8 control store
    wr(4'h4, 16'h1C01);
    chk_rd(4'h4, 32'h1C01, "R8 control stores value");
    wr(4'h4, 16'h3C01);
    chk_pulse(3'b000, "R10 sleep type 7 raises nothing");
    chk_rd(4'h4, 32'h1C01, "R8 sleep enable not stored");

    // R9 power-off
    wr(4'h4, 16'h2000);
    chk_pulse(3'b100, "R9 shutdown request pulse");
    chk_pulse(3'b000, "R9 shutdown request ends");
    chk_rd(4'h4, 32'h0, "R8 control after type 0");

    // R10 suspend
    wr(4'h4, 16'h2400);
    chk_pulse(3'b011, "R10 reset and s3 pulse");
    chk_pulse(3'b000, "R10 pulses end");
    chk_rd(4'h0, 32'h8100, "R10 wake and button status set");
    chk_rd(4'h4, 32'h0400, "R8 control after type 1");
    wr(4'h0, 16'hFFFF);

    // R11 command byte
    apm(8'hF1);
    chk_rd(4'h4, 32'h0401, "R11 0xF1 sets sci enable");
    apm(8'h55);
    chk_rd(4'h4, 32'h0401, "R11 other byte ignored");
    apm(8'hF0);
    chk_rd(4'h4, 32'h0400, "R11 0xF0 clears sci enable");

    // R2 window disabled
    io_en = 1'b0;
    wr(4'h2, 16'hAAAA);
    chk_rd(4'h2, 32'h0, "R2 read with window off is zero");
    io_en = 1'b1;
    chk_rd(4'h2, 32'h0100, "R2 write with window off ignored");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule